// File: doc/BRIEF.md
# Protection Entry Configuration Register File

This block holds the control state of a physical memory protection unit. It has a bank of protection entries. Each entry has an 8-bit configuration byte and an XLEN-wide address register. The bank also has one security-control register. Software reaches all of it through a single-cycle register port. A write names a register class, an index and a data word. A read returns the addressed register at once, through combinational logic.

Every write is filtered against the current lock state before it lands. An entry's lock bit can freeze that entry. The next entry can freeze an address register when it is a locked top-of-range rule. The security register adds three controls. The rule-lock bypass bit reopens locked entries. The lockdown bit replaces the plain lock rule with a rule that looks at the written value. The whitelist bit is stored and held. A write that fails the filter is dropped without any indication. The stored values go out raw on wide ports, for the address-match and permission logic that sits downstream.

Packed configuration registers carry one byte per entry, XLEN/8 bytes each. Byte b of configuration register k belongs to entry k*(XLEN/8)+b.

Top module: `prot_cfg_regfile`

## Requirements
- R1: After reset, every configuration byte, every address register and the security register read as zero.
- R2: A configuration write with register class 0 and index k stores byte b of the data (bits 8b+7:8b) into entry k*(XLEN/8)+b. This applies while lockdown is clear and the entry's lock bit (bit 7) is clear. Byte fields are bit0 read, bit1 write, bit2 execute, bits 4:3 match mode (1 = top-of-range), bit7 lock.
- R3: While lockdown (security bit 0) and bypass (security bit 2) are both clear, a configuration write to an entry whose lock bit is set leaves that byte unchanged.
- R4: While bypass is set, a configuration write is accepted whatever the lock bit or lockdown state.
- R5: While lockdown is set, a configuration byte that sets lock and clears execute is accepted, even into a locked entry.
- R6: While lockdown is set and bypass is clear, these bytes are accepted: bytes with lock clear whose low three bits are not exactly write+execute (3'b110). Bytes with lock set and execute set are dropped, and so are unlocked 3'b110 bytes, even for an unlocked entry.
- R7: An address write (register class 1, index i) is dropped when entry i is locked.
- R8: An address write to entry i is also dropped when entry i+1 is locked with match mode top-of-range. The last entry has no such neighbour.
- R9: Security bits 0 (lockdown) and 1 (whitelist) are sticky. Once set, no write clears them before reset.
- R10: A security write (register class 2) cannot change the bypass bit from 0 to 1 while any entry is locked. Otherwise the written bits are stored.
- R11: Writes to a configuration or address index beyond the bank, and writes with register class 3, change nothing. Reads of such indices return zero.
- R12: A read returns the stored value of the addressed register in the same cycle. Accepted writes show on the outputs after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Write strobe |
| csr_sel_i | input | 2 | Register class: 0 config, 1 address, 2 security, 3 none |
| csr_idx_i | input | IDX_W | Register index within the class |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data for the addressed register |
| cfg_o | output | NUM_ENTRIES*8 | All configuration bytes, entry i at bits 8i+7:8i |
| addr_o | output | NUM_ENTRIES*XLEN | All address registers, entry i at slice i |
| sec_o | output | 3 | Security register: bit0 lockdown, bit1 whitelist, bit2 bypass |

## Verification
Assertions check the drop rules on every cycle, each in its own unit:
- locked bytes hold while lockdown and bypass are clear;
- bypass writes land;
- lockdown rejects lock-plus-execute bytes;
- address registers hold under their own lock or a locked top-of-range neighbour;
- the sticky security bits and the blocked bypass never regress;
- out-of-range addresses do nothing and read zero.

Only the bench scenarios show the rest: the packed byte-to-entry mapping across a whole word, the last entry with no neighbour, and acceptance under a mixed lockdown word. Those scenarios also show that a reset between phases restores the open state. A reference model runs alongside for a long random sequence.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
  localparam int unsigned CFG_R = 0;
  localparam int unsigned CFG_W = 1;
  localparam int unsigned CFG_X = 2;
  localparam int unsigned CFG_L = 7;

  localparam int unsigned SEC_MML  = 0;
  localparam int unsigned SEC_MMWP = 1;
  localparam int unsigned SEC_RLB  = 2;
  localparam int unsigned SEC_W    = 3;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  function automatic match_mode_e cfg_mode(input logic [7:0] c);
    return match_mode_e'(c[4:3]);
  endfunction
endpackage

// File: rtl/prot_cfg_entry.sv
module prot_cfg_entry
  import prot_cfg_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_wdata_i,
  input  logic            addr_we_i,
  input  logic [XLEN-1:0] addr_wdata_i,
  input  logic            next_tor_lock_i,
  input  logic            mml_i,
  input  logic            rlb_i,
  output logic [7:0]      cfg_o,
  output logic [XLEN-1:0] addr_o,
  output logic            locked_o,
  output logic            tor_locked_o
);
  logic [7:0]      cfg_q;
  logic [XLEN-1:0] addr_q;
  logic            lock_q;
  logic            wr_lock, wr_x;
  logic            mml_ok, cfg_ok, addr_ok;

  assign lock_q  = cfg_q[CFG_L];
  assign wr_lock = cfg_wdata_i[CFG_L];
  assign wr_x    = cfg_wdata_i[CFG_X];

  // lockdown admits lock-without-exec, or unlocked bytes that are not the W+X code
  always_comb begin
    mml_ok = wr_lock ? !wr_x : (cfg_wdata_i[2:0] != 3'b110);
    if (rlb_i)       cfg_ok = 1'b1;
    else if (mml_i)  cfg_ok = mml_ok;
    else             cfg_ok = !lock_q;
  end

  assign addr_ok = !lock_q && !next_tor_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_we_i && cfg_ok)   cfg_q  <= cfg_wdata_i;
      if (addr_we_i && addr_ok) addr_q <= addr_wdata_i;
    end
  end

  assign cfg_o        = cfg_q;
  assign addr_o       = addr_q;
  assign locked_o     = lock_q;
  assign tor_locked_o = lock_q && (cfg_mode(cfg_q) == MODE_TOR);

  a_r3_locked_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && lock_q && !rlb_i && !mml_i |=> $stable(cfg_q));
  a_r4_bypass_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && rlb_i |=> cfg_q == $past(cfg_wdata_i));
  a_r6_mml_lock_exec_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && mml_i && !rlb_i && cfg_wdata_i[CFG_L] && cfg_wdata_i[CFG_X] |=> $stable(cfg_q));
  a_r7_addr_own_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_we_i && lock_q |=> $stable(addr_q));
  a_r8_addr_next_tor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_we_i && next_tor_lock_i |=> $stable(addr_q));
endmodule

// File: rtl/prot_cfg_sec.sv
module prot_cfg_sec
  import prot_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEC_W-1:0] wdata_i,
  input  logic             any_lock_i,
  output logic [SEC_W-1:0] sec_o
);
  logic [SEC_W-1:0] sec_q, sec_d;

  always_comb begin
    sec_d = wdata_i;
    if (!sec_q[SEC_RLB] && any_lock_i) sec_d[SEC_RLB] = 1'b0;
    sec_d[SEC_MML]  = sec_d[SEC_MML]  | sec_q[SEC_MML];
    sec_d[SEC_MMWP] = sec_d[SEC_MMWP] | sec_q[SEC_MMWP];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sec_q <= '0;
    else if (we_i) sec_q <= sec_d;
  end

  assign sec_o = sec_q;

  a_r9_mml_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q[SEC_MML] |=> sec_q[SEC_MML]);
  a_r9_mmwp_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q[SEC_MMWP] |=> sec_q[SEC_MMWP]);
  a_r10_rlb_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_q[SEC_RLB] && any_lock_i |=> !sec_q[SEC_RLB]);
endmodule

// File: rtl/prot_cfg_regfile.sv
module prot_cfg_regfile
  import prot_cfg_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned IDX_W       = $clog2(NUM_ENTRIES) + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        csr_we_i,
  input  logic [1:0]                  csr_sel_i,
  input  logic [IDX_W-1:0]            csr_idx_i,
  input  logic [XLEN-1:0]             csr_wdata_i,
  output logic [XLEN-1:0]             csr_rdata_o,
  output logic [NUM_ENTRIES*8-1:0]    cfg_o,
  output logic [NUM_ENTRIES*XLEN-1:0] addr_o,
  output logic [SEC_W-1:0]            sec_o
);
  localparam int unsigned BYTES    = XLEN / 8;
  localparam int unsigned CFG_REGS = (NUM_ENTRIES + BYTES - 1) / BYTES;
  localparam int unsigned ENT_W    = $clog2(NUM_ENTRIES);

  csr_sel_e         sel;
  logic [7:0]       cfg_arr  [NUM_ENTRIES];
  logic [XLEN-1:0]  addr_arr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] locked, tor_locked;
  logic [SEC_W-1:0] sec_q;

  assign sel = csr_sel_e'(csr_sel_i);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic cfg_we, addr_we, next_tor;
    assign cfg_we  = csr_we_i && (sel == SEL_CFG)  && (csr_idx_i == IDX_W'(i / BYTES));
    assign addr_we = csr_we_i && (sel == SEL_ADDR) && (csr_idx_i == IDX_W'(i));
    if (i == NUM_ENTRIES - 1) begin : g_last
      assign next_tor = 1'b0;
    end else begin : g_mid
      assign next_tor = tor_locked[i+1];
    end

    prot_cfg_entry #(.XLEN(XLEN)) u_entry (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .cfg_we_i        (cfg_we),
      .cfg_wdata_i     (csr_wdata_i[(i % BYTES)*8 +: 8]),
      .addr_we_i       (addr_we),
      .addr_wdata_i    (csr_wdata_i),
      .next_tor_lock_i (next_tor),
      .mml_i           (sec_q[SEC_MML]),
      .rlb_i           (sec_q[SEC_RLB]),
      .cfg_o           (cfg_arr[i]),
      .addr_o          (addr_arr[i]),
      .locked_o        (locked[i]),
      .tor_locked_o    (tor_locked[i])
    );

    assign cfg_o[i*8 +: 8]       = cfg_arr[i];
    assign addr_o[i*XLEN +: XLEN] = addr_arr[i];
  end

  prot_cfg_sec u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (csr_we_i && (sel == SEL_SEC)),
    .wdata_i    (csr_wdata_i[SEC_W-1:0]),
    .any_lock_i (|locked),
    .sec_o      (sec_q)
  );

  assign sec_o = sec_q;

  always_comb begin
    int e;
    e = 0;
    csr_rdata_o = '0;
    unique case (sel)
      SEL_CFG: begin
        if (int'(csr_idx_i) < CFG_REGS) begin
          for (int b = 0; b < BYTES; b++) begin
            e = int'(csr_idx_i) * BYTES + b;
            if (e < NUM_ENTRIES) csr_rdata_o[b*8 +: 8] = cfg_arr[e];
          end
        end
      end
      SEL_ADDR: begin
        if (int'(csr_idx_i) < NUM_ENTRIES) csr_rdata_o = addr_arr[csr_idx_i[ENT_W-1:0]];
      end
      SEL_SEC:  csr_rdata_o[SEC_W-1:0] = sec_q;
      default:  csr_rdata_o = '0;
    endcase
  end

  a_r11_oob_addr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i && sel == SEL_ADDR && int'(csr_idx_i) >= NUM_ENTRIES |=> $stable(addr_o) && $stable(cfg_o));
  a_r11_oob_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i && sel == SEL_CFG && int'(csr_idx_i) >= CFG_REGS |=> $stable(addr_o) && $stable(cfg_o));
  a_r11_oob_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel == SEL_ADDR && int'(csr_idx_i) >= NUM_ENTRIES |-> csr_rdata_o == '0);
endmodule

// File: tb/prot_cfg_regfile_bench.sv
module prot_cfg_regfile_bench;
  localparam int N = 16;
  localparam int XL = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0;
  logic [1:0] sel = 2'd3;
  logic [IW-1:0] idx = '0;
  logic [XL-1:0] wdata = '0;
  logic [XL-1:0] rdata;
  logic [N*8-1:0] cfg_o;
  logic [N*XL-1:0] addr_o;
  logic [2:0] sec_o;

  always #4 clk = ~clk;

  prot_cfg_regfile u_prot_cfg_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(we), .csr_sel_i(sel), .csr_idx_i(idx),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .cfg_o(cfg_o), .addr_o(addr_o), .sec_o(sec_o));

  logic [7:0]  m_cfg [N];
  logic [31:0] m_addr[N];
  logic [2:0]  m_sec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] m_read(input int s, input int i);
    logic [31:0] r = '0;
    if (s == 0 && i < N/4) for (int b = 0; b < 4; b++) r[b*8 +: 8] = m_cfg[i*4+b];
    else if (s == 1 && i < N) r = m_addr[i];
    else if (s == 2) r = {29'd0, m_sec};
    return r;
  endfunction

  task automatic m_apply(input int s, input int i, input logic [31:0] d);
    bit any_l = 0;
    for (int e = 0; e < N; e++) if (m_cfg[e][7]) any_l = 1;
    if (s == 0 && i < N/4) begin
      for (int b = 0; b < 4; b++) begin
        logic [7:0] v = d[b*8 +: 8];
        int e = i*4 + b;
        bit ok;
        if (m_sec[2]) ok = 1;
        else if (!m_sec[0]) ok = !m_cfg[e][7];
        else if (v[7]) ok = !v[2];
        else ok = (v[2:0] != 3'b110);
        if (ok) m_cfg[e] = v;
      end
    end else if (s == 1 && i < N) begin
      bit blk = m_cfg[i][7];
      if (i < N-1 && m_cfg[i+1][7] && m_cfg[i+1][4:3] == 2'b01) blk = 1;
      if (!blk) m_addr[i] = d;
    end else if (s == 2) begin
      logic [2:0] nv = d[2:0];
      if (!m_sec[2] && any_l) nv[2] = 0;
      nv[1:0] = nv[1:0] | m_sec[1:0];
      m_sec = nv;
    end
  endtask

  task automatic check_state(input string tag);
    logic [N*8-1:0] ec;
    logic [N*XL-1:0] ea;
    for (int e = 0; e < N; e++) begin
      ec[e*8 +: 8] = m_cfg[e];
      ea[e*XL +: XL] = m_addr[e];
    end
    n_chk++;
    if (cfg_o !== ec || addr_o !== ea || sec_o !== m_sec) begin
      n_fail++;
      $display("FAIL %s state: cfg=%h addr=%h sec=%h expected cfg=%h addr=%h sec=%h",
               tag, cfg_o, addr_o, sec_o, ec, ea, m_sec);
    end
  endtask

  // drive at negedge, check read before edge, check state after edge
  task automatic op(input int s, input int i, input logic [31:0] d, input bit w, input string tag);
    logic [31:0] er;
    sel = 2'(s); idx = IW'(i); wdata = d; we = w;
    #1;
    er = m_read(s, i);
    n_chk++;
    if (rdata !== er) begin
      n_fail++;
      $display("FAIL %s read sel=%0d idx=%0d: got %h expected %h", tag, s, i, rdata, er);
    end
    @(posedge clk);
    if (w) m_apply(s, i, d);
    @(negedge clk);
    we = 0;
    check_state(tag);
  endtask

  task automatic do_reset();
    rst_ni = 0; we = 0;
    for (int e = 0; e < N; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
    m_sec = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    check_state("R1 reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    op(0, 0, 32'h0, 0, "R1 cfg read zero");
    op(0, 0, 32'h0F0E0B03, 1, "R2 packed write");
    op(0, 0, 32'h0, 0, "R12 readback");
    op(0, 1, 32'h00008B00, 1, "R2 lock entry5 tor");
    op(0, 1, 32'h11220722, 1, "R3 locked byte held");
    op(1, 5, 32'hAAAA0001, 1, "R7 own lock");
    op(1, 4, 32'hBBBB0002, 1, "R8 next tor locked");
    op(1, 3, 32'hCCCC0003, 1, "R12 addr write");
    op(1, 3, 32'h0, 0, "R12 addr read");
    op(0, 3, 32'h80000000, 1, "R8 lock last entry");
    op(1, 14, 32'h14141414, 1, "R8 next locked not tor");
    op(1, 15, 32'h15151515, 1, "R8 last own lock");
    op(2, 0, 32'h4, 1, "R10 rlb blocked");
    op(1, 20, 32'hDEADBEEF, 1, "R11 oob addr write");
    op(1, 20, 32'h0, 0, "R11 oob addr read");
    op(0, 5, 32'hFFFFFFFF, 1, "R11 oob cfg write");
    op(3, 0, 32'hFFFFFFFF, 1, "R11 class 3 write");

    do_reset();
    op(2, 0, 32'h4, 1, "R10 rlb set");
    op(0, 0, 32'h00000081, 1, "R4 lock entry0");
    op(0, 0, 32'h00000003, 1, "R4 bypass rewrite");
    op(0, 0, 32'h00000081, 1, "R4 relock");
    op(2, 0, 32'h0, 1, "R10 rlb clear");
    op(2, 0, 32'h4, 1, "R10 rlb reblocked");
    op(2, 0, 32'h3, 1, "R9 set sticky");
    op(2, 0, 32'h0, 1, "R9 sticky hold");
    op(0, 0, 32'h84050683, 1, "R5 R6 lockdown mix");
    op(0, 0, 32'h0, 0, "R6 readback");

    do_reset();
    for (int k = 0; k < 600; k++) begin
      int s = $urandom_range(0, 3);
      int i = $urandom_range(0, 23);
      logic [31:0] d = $urandom;
      if (k < 300 && s == 2) d[1:0] = 2'b00;
      op(s, i, d, 1'($urandom_range(0, 1)), "R12 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule